// File: doc/BRIEF.md
# Trimmed Real-Time Counter with Wrap Status and Sticky Wrap Events

This block is the counting core of a wake-up timer. On every prescaled time-unit strobe it advances a wide real-time count and, in parallel, a separate modulo-60 view of that count. A signed trim input adjusts each step. A positive trim makes the step longer by the trim amount. A negative trim makes the block skip that increment. Because a trimmed step can jump over the exact boundary, a wrap is detected by comparing the value before and after the step. A check for one fixed transition would miss it.

Each view reports its wrap in two forms. A live status bit shows whether the value now held came from a wrap at the most recent strobe. A strobe that does not wrap clears it, so software that reacts late sees 0. A sticky event flag is set by the wrap and stays set until software writes a 1 to its clear strobe. The interrupt line is the OR of the sticky flags whose enables are set. Generation of the strobe, bus decoding and alarm comparison are handled elsewhere.

Top module: `rtc_wrap_counter`

## Requirements
- R1: After reset, count, modulo-60 value, both live status bits, both sticky flags and the interrupt are all 0.
- R2: On a cycle with `tick` high, the count grows by a step of 1 + `trim` when `trim` (two's complement) is zero or positive. A negative `trim` gives a step of 0. The count wraps modulo 2^CNT_W. With `tick` low, the count holds.
- R3: The modulo-60 value always lies in 0..59. It grows by the same step on each tick and wraps modulo 60, so with positive trim a wrap takes fewer than 60 ticks.
- R4: Sticky bit 0 of `evt_flags` is set by every tick on which the modulo-60 value wraps. It stays set until `evt_clr[0]` is 1 on a cycle without a new wrap. A wrap in the same cycle as a clear leaves it set.
- R5: `live_mod_wrap` becomes 1 after a tick on which the modulo-60 value wrapped and 0 after a tick on which it did not. Between ticks it holds.
- R6: `live_cnt_wrap` becomes 1 after a tick on which the count passed its maximum and wrapped, and 0 after a tick on which it did not. Between ticks it holds.
- R7: Sticky bit 1 of `evt_flags` is set by every count wrap and is cleared the same way as bit 0, through `evt_clr[1]`.
- R8: `irq` is 1 exactly when some bit of `evt_flags` is 1 and the matching bit of `evt_en` is 1.
- R9: A 0 on an `evt_clr` bit leaves the matching sticky flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled time-unit strobe, one cycle per increment |
| trim | input | TRIM_W | Signed step adjustment applied with a tick |
| evt_clr | input | 2 | Write-one-to-clear strobes; bit 0 modulo-60, bit 1 count |
| evt_en | input | 2 | Interrupt enables, same bit order as `evt_flags` |
| count | output | CNT_W | Real-time count |
| mod60 | output | 6 | Modulo-60 view |
| live_mod_wrap | output | 1 | Modulo-60 value came from a wrap at last tick |
| live_cnt_wrap | output | 1 | Count came from a wrap at last tick |
| evt_flags | output | 2 | Sticky wrap events; bit 0 modulo-60, bit 1 count |
| irq | output | 1 | Interrupt request |

## Verification
The assertions expect `tick` to be a clean one-cycle strobe per increment and `trim` to stay inside its signed range. They also expect the largest step to be shorter than 60, so one step can wrap the modulo-60 view no more than once. The parameter check enforces this limit. The stimulus uses only trims from -8 to 7 in a 4-bit field. It shrinks the count to 10 bits so that a count wrap occurs within a few hundred ticks. It places clear strobes both on quiet cycles and on the exact cycle of a wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned RTC_MOD60  = 60;
   localparam int unsigned RTC_NSRC   = 2;
   localparam int unsigned SRC_MOD    = 0;
   localparam int unsigned SRC_CNT    = 1;
   typedef logic [RTC_NSRC-1:0] rtc_src_t;
endpackage

// File: rtl/rtc_wrap_stepper.sv
module rtc_wrap_stepper #(
   parameter int unsigned W       = 32,
   parameter int unsigned MODULUS = 0,   // 0 selects natural 2**W wrap
   parameter int unsigned STEP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [STEP_W-1:0] step,
   output logic [W-1:0]      value,
   output logic              wrap_evt,
   output logic              wrapped_live
);
   localparam int unsigned SUM_W = W + 1;

   logic [W-1:0] value_nx;

   generate
      if (MODULUS == 0) begin : g_natural
         logic [SUM_W-1:0] sum;
         always_comb begin
            sum      = {1'b0, value} + SUM_W'(step);
            value_nx = sum[W-1:0];
            wrap_evt = adv & sum[W];
         end
      end else begin : g_modulo
         if (MODULUS > (1 << W)) begin : g_bad_w
            $error("rtc_wrap_stepper: MODULUS does not fit in W bits");
         end
         if ((1 << STEP_W) - 1 >= MODULUS) begin : g_bad_step
            $error("rtc_wrap_stepper: step range must stay below MODULUS");
         end
         logic [SUM_W-1:0] sum;
         logic             over;
         always_comb begin
            sum      = {1'b0, value} + SUM_W'(step);
            over     = (sum >= SUM_W'(MODULUS));
            value_nx = over ? W'(sum - SUM_W'(MODULUS)) : sum[W-1:0];
            wrap_evt = adv & over;
         end

         a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            value < W'(MODULUS));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value        <= '0;
         wrapped_live <= 1'b0;
      end else if (adv) begin
         value        <= value_nx;
         wrapped_live <= wrap_evt;
      end
   end

   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(value));
   a_r5_live_set: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap_evt) |=> wrapped_live);
   a_r5_live_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wrap_evt) |=> !wrapped_live);
   a_r6_live_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(wrapped_live));
endmodule

// File: rtl/rtc_sticky_bank.sv
module rtc_sticky_bank #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);
   if (N < 1) begin : g_bad_n
      $error("rtc_sticky_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);
      a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr[i]) |=> flags[i]);
      a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
   end

   assign irq = |(flags & en);
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter
   import rtc_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned TRIM_W = 4,
   localparam int unsigned MOD_W = $clog2(RTC_MOD60)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic signed [TRIM_W-1:0] trim,
   input  logic [RTC_NSRC-1:0]      evt_clr,
   input  logic [RTC_NSRC-1:0]      evt_en,
   output logic [CNT_W-1:0]         count,
   output logic [MOD_W-1:0]         mod60,
   output logic                     live_mod_wrap,
   output logic                     live_cnt_wrap,
   output logic [RTC_NSRC-1:0]      evt_flags,
   output logic                     irq
);
   localparam int unsigned STEP_W = TRIM_W;

   if (TRIM_W < 2) begin : g_bad_trim
      $error("rtc_wrap_counter: TRIM_W must be at least 2");
   end
   if (CNT_W < MOD_W) begin : g_bad_cnt
      $error("rtc_wrap_counter: CNT_W too narrow");
   end

   logic [STEP_W-1:0] step;
   rtc_src_t          wrap_set;
   logic              mod_evt, cnt_evt;

   // Negative trim suppresses the increment; otherwise step = 1 + trim.
   always_comb begin
      if (trim[TRIM_W-1]) step = '0;
      else                step = STEP_W'(trim) + STEP_W'(1);
   end

   rtc_wrap_stepper #(.W(CNT_W), .MODULUS(0), .STEP_W(STEP_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(tick), .step(step),
      .value(count), .wrap_evt(cnt_evt), .wrapped_live(live_cnt_wrap));

   rtc_wrap_stepper #(.W(MOD_W), .MODULUS(RTC_MOD60), .STEP_W(STEP_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .adv(tick), .step(step),
      .value(mod60), .wrap_evt(mod_evt), .wrapped_live(live_mod_wrap));

   always_comb begin
      wrap_set          = '0;
      wrap_set[SRC_MOD] = mod_evt;
      wrap_set[SRC_CNT] = cnt_evt;
   end

   rtc_sticky_bank #(.N(RTC_NSRC)) u_evt (
      .clk(clk), .rst_n(rst_n), .set(wrap_set), .clr(evt_clr), .en(evt_en),
      .flags(evt_flags), .irq(irq));

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (count == '0 && mod60 == '0 && evt_flags == '0));
   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_flags != '0));
endmodule

// File: tb/sim_rtc_wrap_counter.sv
module sim_rtc_wrap_counter;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 10;
   localparam int TW = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic signed [TW-1:0] trim = '0;
   logic [1:0] evt_clr = '0, evt_en = '0;
   logic [CW-1:0] count;
   logic [5:0] mod60;
   logic live_mod_wrap, live_cnt_wrap, irq;
   logic [1:0] evt_flags;

   int checks = 0, errors = 0;
   int m_cnt = 0, m_mod = 0;
   bit m_lm = 0, m_lc = 0;
   bit [1:0] m_stk = '0;
   bit saw_cnt_wrap = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_wrap_counter #(.CNT_W(CW), .TRIM_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trim(trim), .evt_clr(evt_clr),
      .evt_en(evt_en), .count(count), .mod60(mod60),
      .live_mod_wrap(live_mod_wrap), .live_cnt_wrap(live_cnt_wrap),
      .evt_flags(evt_flags), .irq(irq));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2", "count", int'(count), m_cnt);
      chk("R3", "mod60", int'(mod60), m_mod);
      chk("R5", "live_mod_wrap", int'(live_mod_wrap), int'(m_lm));
      chk("R6", "live_cnt_wrap", int'(live_cnt_wrap), int'(m_lc));
      chk("R4", "evt_flags[0]", int'(evt_flags[0]), int'(m_stk[0]));
      chk("R7", "evt_flags[1]", int'(evt_flags[1]), int'(m_stk[1]));
      chk("R8", "irq", int'(irq), int'(|(m_stk & evt_en)));
   endtask

   // One clock: drive at falling edge, update model, compare after rising edge.
   task automatic cycle(input bit t, input int tr, input bit [1:0] clr, input bit do_check);
      int step, s;
      bit wc, wm;
      @(negedge clk);
      tick = t; trim = TW'(tr); evt_clr = clr;
      @(posedge clk); #1;
      tick = 1'b0; evt_clr = '0;
      wc = 0; wm = 0;
      if (t) begin
         step = (tr < 0) ? 0 : tr + 1;
         s = m_cnt + step; wc = (s >= (1 << CW)); m_cnt = s % (1 << CW);
         s = m_mod + step; wm = (s >= 60); m_mod = s % 60;
         m_lm = wm; m_lc = wc;
         if (wc) saw_cnt_wrap = 1;
      end
      m_stk = (m_stk & ~clr) | {wc, wm};
      if (do_check) check_all();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      m_cnt = 0; m_mod = 0; m_lm = 0; m_lc = 0; m_stk = '0;
      chk("R1", "count", int'(count), 0);
      chk("R1", "mod60", int'(mod60), 0);
      chk("R1", "live bits", int'({live_mod_wrap, live_cnt_wrap}), 0);
      chk("R1", "flags", int'(evt_flags), 0);
      chk("R1", "irq", int'(irq), 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_plain_mod_wrap();
      evt_en = 2'b01;
      for (int i = 0; i < 59; i++) cycle(1, 0, 2'b00, 0);
      check_all();
      chk("R3", "mod60 at 59", int'(mod60), 59);
      cycle(1, 0, 2'b00, 1);
      chk("R3", "mod60 wrapped", int'(mod60), 0);
      chk("R5", "live after wrap", int'(live_mod_wrap), 1);
      chk("R4", "sticky set", int'(evt_flags[0]), 1);
      chk("R8", "irq enabled", int'(irq), 1);
      cycle(1, 0, 2'b00, 1);
      chk("R5", "live dropped late", int'(live_mod_wrap), 0);
      chk("R4", "sticky held", int'(evt_flags[0]), 1);
   endtask

   task automatic t_idle_and_zero_write();
      for (int i = 0; i < 4; i++) cycle(0, 3, 2'b00, 1);
      chk("R9", "zero write keeps flag", int'(evt_flags[0]), 1);
      evt_en = 2'b10;
      #1 chk("R8", "irq masked", int'(irq), 0);
      evt_en = 2'b01;
      cycle(0, 0, 2'b01, 1);
      chk("R4", "cleared by one", int'(evt_flags[0]), 0);
      chk("R8", "irq after clear", int'(irq), 0);
   endtask

   task automatic t_trim_steps();
      for (int i = 0; i < 6; i++) cycle(1, 5, 2'b00, 1);
      for (int i = 0; i < 3; i++) cycle(1, -1, 2'b00, 1);
      cycle(1, -8, 2'b00, 1);
      for (int i = 0; i < 12; i++) cycle(1, 7, 2'b00, 1);
      chk("R3", "trimmed wrap count", int'(evt_flags[0]), 1);
   endtask

   task automatic t_clear_during_wrap();
      cycle(0, 0, 2'b01, 1);
      while (m_mod + 8 < 60) cycle(1, 7, 2'b00, 1);
      cycle(1, 7, 2'b01, 1);
      chk("R4", "set beats clear", int'(evt_flags[0]), 1);
   endtask

   task automatic t_count_wrap();
      evt_en = 2'b10;
      for (int i = 0; i < 200 && !saw_cnt_wrap; i++) cycle(1, 7, 2'b00, 1);
      chk("R6", "count wrap reached", int'(saw_cnt_wrap), 1);
      chk("R6", "live count wrap", int'(live_cnt_wrap), 1);
      chk("R7", "count sticky", int'(evt_flags[1]), 1);
      chk("R8", "irq from count", int'(irq), 1);
      cycle(1, 0, 2'b00, 1);
      chk("R6", "live count dropped", int'(live_cnt_wrap), 0);
      cycle(0, 0, 2'b10, 1);
      chk("R7", "count sticky cleared", int'(evt_flags[1]), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_plain_mod_wrap();
      t_idle_and_zero_write();
      t_trim_steps();
      t_clear_during_wrap();
      t_count_wrap();
      t_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule